// File: doc/BRIEF.md
# Buffered Byte-Serial SPI Master

This block is a byte-oriented SPI master that a host drives through three small registers: a control/status register, a transmit holding register and a receive holding register. The host writes a byte into the transmit holding register. The block moves that byte into its shifter, generates eight SCLK periods and drives MOSI, and samples MISO during those periods. When the byte is finished, the block places the captured byte into the receive holding register.

The transmit side has one byte of buffering. A byte written while the shifter is busy waits in the holding register. It starts at the SCLK edge right after the current byte's last edge, so no extra idle time appears on the wire. SCLK is the system clock divided by `2*HALF_DIV`.

The control/status register carries four things:
- The configuration: bit order, clock phase, clock polarity and enable.
- Sticky flags: transfer done, receive full and overrun. Reading the control register or the receive register clears some of these.
- A transmit-empty flag.
- A single level interrupt. It follows either transmit-empty or transfer-done, as chosen by an input pin.

Top module: `bspi_master`

## Requirements
- R1: After reset the control register (address 0) reads 8'h10, the receive register (address 2) reads 8'h00, and sclk, mosi and irq are low; addresses 1 and 3 read 8'h00.
- R2: Control register bits are: 7 = LSB-first, 6 = overrun, 5 = transfer done, 4 = TX empty, 3 = RX full, 2 = phase, 1 = polarity, 0 = enable. Bits 7, 2 and 1 take the written value only while enable is 0 (including the write that sets enable). While enabled, a control write changes only bit 0.
- R3: SCLK rests at the polarity bit whenever no byte is in flight. Each byte produces exactly 16 SCLK transitions, spaced HALF_DIV system clocks apart.
- R4: With bit 7 = 0 MOSI carries the byte MSB first; with bit 7 = 1 it carries it LSB first.
- R5: With phase 0, MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge. With phase 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. The eight samples, assembled in the selected bit order, form the received byte.
- R6: A write to address 1 while enabled clears TX empty. TX empty sets again when the byte enters the shifter. A byte waiting behind a busy shifter starts with no gap wider than HALF_DIV clocks. Writes to address 1 while disabled are ignored, and TX empty reads 1 while disabled.
- R7: Transfer done sets once all 16 transitions of a byte have been produced and clears on a read of the control register.
- R8: RX full sets when a received byte is loaded into the receive register and clears on a read of address 2. Overrun sets when a byte is loaded while RX full is still set and clears on a read of the control register.
- R9: With irq_sel = 0, irq equals TX empty, but only after a byte has entered the shifter since the last enable. With irq_sel = 1, irq equals transfer done.
- R10: Clearing enable aborts a byte in flight: SCLK returns to the polarity level, MOSI goes low, no transfer-done or receive event follows, and TX empty reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register select: 0 control/status, 1 TX, 2 RX |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; triggers clear-on-read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_sel | input | 1 | Interrupt source: 0 TX empty, 1 transfer done |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with HALF_DIV = 2, which makes one byte about 34 system clocks long. With bytes that short, the bench can sweep every combination of polarity, phase and bit order over 86 distinct transmit/receive byte pairs. It can also cover back-to-back bytes, overrun, interrupt arming, the configuration lock and a mid-byte abort within the cycle budget. A behavioural slave in the bench tracks SCLK transitions to check the spacing between them, captures MOSI, and drives MISO from its own edge count.

// File: rtl/bspi_pkg.sv
package bspi_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TX   = 2'd1;
  localparam logic [1:0] ADDR_RX   = 2'd2;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_CPOL = 1;
  localparam int unsigned CB_CPHA = 2;
  localparam int unsigned CB_LSB  = 7;

  // bit presented on the line for the current shifter content
  function automatic logic tx_bit(input logic [BYTE_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[BYTE_W-1];
  endfunction

  // shifter content after one bit has left
  function automatic logic [BYTE_W-1:0] tx_advance(input logic [BYTE_W-1:0] v, input logic lsb);
    return lsb ? {1'b0, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], 1'b0};
  endfunction

  // receive shifter content after one sampled bit
  function automatic logic [BYTE_W-1:0] rx_insert(input logic [BYTE_W-1:0] v, input logic b,
                                                  input logic lsb);
    return lsb ? {b, v[BYTE_W-1:1]} : {v[BYTE_W-2:0], b};
  endfunction

  function automatic logic [7:0] pack_ctrl(input logic lsb, input logic ovr, input logic done,
                                           input logic txe, input logic rxf, input logic cpha,
                                           input logic cpol, input logic en);
    return {lsb, ovr, done, txe, rxf, cpha, cpol, en};
  endfunction
endpackage

// File: rtl/bspi_timer.sv
module bspi_timer #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned BITS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cpol,
  input  logic start,
  output logic busy,
  output logic tick,
  output logic lead_ev,
  output logic trail_ev,
  output logic last_ev,
  output logic sclk
);
  localparam int unsigned EDGES = 2 * BITS;
  localparam int unsigned CW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned EW    = $clog2(EDGES);

  logic [CW-1:0] div_q;
  logic [EW-1:0] edge_q;
  logic          busy_q;
  logic          sclk_q;

  assign tick     = en && busy_q && (div_q == CW'(HALF_DIV - 1));
  assign lead_ev  = tick && !edge_q[0];
  assign trail_ev = tick && edge_q[0];
  assign last_ev  = tick && (edge_q == EW'(EDGES - 1));
  assign busy     = busy_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      sclk_q <= 1'b0;
    end else if (!en) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      sclk_q <= cpol;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        div_q  <= '0;
        edge_q <= '0;
      end else if (busy_q) begin
        if (tick) begin
          div_q  <= '0;
          edge_q <= edge_q + 1'b1;
          if (last_ev) busy_q <= 1'b0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
      if (tick) sclk_q <= ~sclk_q;
      else if (!busy_q && !start) sclk_q <= cpol;
    end
  end
endmodule

// File: rtl/bspi_shifter.sv
module bspi_shifter
  import bspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              lsb_first,
  input  logic              cpha,
  input  logic              start,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              lead_ev,
  input  logic              trail_ev,
  input  logic              last_ev,
  input  logic              miso,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_word
);
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic              mosi_q;
  logic              drive_ev;
  logic              sample_ev;

  assign drive_ev  = cpha ? lead_ev : (trail_ev && !last_ev);
  assign sample_ev = cpha ? trail_ev : lead_ev;
  // includes the sample taken in this very cycle so the last bit is not lost
  assign rx_word   = sample_ev ? rx_insert(rx_q, miso, lsb_first) : rx_q;
  assign mosi      = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else if (!en) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else if (start) begin
      rx_q <= '0;
      if (!cpha) begin
        mosi_q <= tx_bit(load_data, lsb_first);
        tx_q   <= tx_advance(load_data, lsb_first);
      end else begin
        tx_q <= load_data;
      end
    end else begin
      if (sample_ev) rx_q <= rx_word;
      if (drive_ev) begin
        mosi_q <= tx_bit(tx_q, lsb_first);
        tx_q   <= tx_advance(tx_q, lsb_first);
      end
    end
  end
endmodule

// File: rtl/bspi_regs.sv
module bspi_regs
  import bspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              irq_sel,
  output logic              irq,
  input  logic              busy,
  input  logic              last_ev,
  input  logic [BYTE_W-1:0] rx_word,
  output logic              start,
  output logic [BYTE_W-1:0] tx_load,
  output logic              cfg_en,
  output logic              cfg_lsb,
  output logic              cfg_cpha,
  output logic              cfg_cpol,
  output logic              stat_txe,
  output logic              stat_done,
  output logic              stat_rxf,
  output logic              stat_ovr,
  output logic              rx_rd,
  output logic              armed
);
  logic              en_q, lsb_q, cpha_q, cpol_q;
  logic              txf_q, rxf_q, done_q, ovr_q, armed_q;
  logic [BYTE_W-1:0] txb_q, rxb_q;
  logic              ctrl_wr, ctrl_rd, tx_wr;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign ctrl_rd = bus_rd && (bus_addr == ADDR_CTRL);
  assign tx_wr   = bus_wr && (bus_addr == ADDR_TX);
  assign rx_rd   = bus_rd && (bus_addr == ADDR_RX);

  assign start   = en_q && txf_q && (!busy || last_ev);
  assign tx_load = txb_q;

  // configuration: locked while enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lsb_q  <= 1'b0;
      cpha_q <= 1'b0;
      cpol_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q <= bus_wdata[CB_EN];
      if (!en_q) begin
        lsb_q  <= bus_wdata[CB_LSB];
        cpha_q <= bus_wdata[CB_CPHA];
        cpol_q <= bus_wdata[CB_CPOL];
      end
    end
  end

  // transmit holding register and interrupt arming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_q   <= '0;
      txf_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (!en_q) begin
      txf_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (tx_wr) begin
        txb_q <= bus_wdata;
        txf_q <= 1'b1;
      end else if (start) begin
        txf_q <= 1'b0;
      end
      if (start) armed_q <= 1'b1;
    end
  end

  // receive side and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q  <= '0;
      rxf_q  <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (last_ev) begin
        rxb_q <= rx_word;
        rxf_q <= 1'b1;
      end else if (rx_rd) begin
        rxf_q <= 1'b0;
      end
      if (last_ev) done_q <= 1'b1;
      else if (ctrl_rd) done_q <= 1'b0;
      if (last_ev && rxf_q && !rx_rd) ovr_q <= 1'b1;
      else if (ctrl_rd) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = pack_ctrl(lsb_q, ovr_q, done_q, !txf_q, rxf_q, cpha_q, cpol_q, en_q);
      ADDR_RX:   bus_rdata = rxb_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq       = irq_sel ? done_q : (armed_q && !txf_q);
  assign cfg_en    = en_q;
  assign cfg_lsb   = lsb_q;
  assign cfg_cpha  = cpha_q;
  assign cfg_cpol  = cpol_q;
  assign stat_txe  = !txf_q;
  assign stat_done = done_q;
  assign stat_rxf  = rxf_q;
  assign stat_ovr  = ovr_q;
  assign armed     = armed_q;
endmodule

// File: rtl/bspi_master.sv
module bspi_master
  import bspi_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_sel,
  output logic       irq,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  logic              cfg_en, cfg_lsb, cfg_cpha, cfg_cpol;
  logic              tmr_busy, tmr_tick, tmr_lead, tmr_trail;
  logic              xfer_start, xfer_last;
  logic [BYTE_W-1:0] tx_load, rx_word;
  logic              stat_txe, stat_done, stat_rxf, stat_ovr;
  logic              rx_rd_pulse, irq_armed;

  bspi_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_sel   (irq_sel),
    .irq       (irq),
    .busy      (tmr_busy),
    .last_ev   (xfer_last),
    .rx_word   (rx_word),
    .start     (xfer_start),
    .tx_load   (tx_load),
    .cfg_en    (cfg_en),
    .cfg_lsb   (cfg_lsb),
    .cfg_cpha  (cfg_cpha),
    .cfg_cpol  (cfg_cpol),
    .stat_txe  (stat_txe),
    .stat_done (stat_done),
    .stat_rxf  (stat_rxf),
    .stat_ovr  (stat_ovr),
    .rx_rd     (rx_rd_pulse),
    .armed     (irq_armed)
  );

  bspi_timer #(
    .HALF_DIV (HALF_DIV),
    .BITS     (BYTE_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_en),
    .cpol     (cfg_cpol),
    .start    (xfer_start),
    .busy     (tmr_busy),
    .tick     (tmr_tick),
    .lead_ev  (tmr_lead),
    .trail_ev (tmr_trail),
    .last_ev  (xfer_last),
    .sclk     (sclk)
  );

  bspi_shifter u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .lsb_first (cfg_lsb),
    .cpha      (cfg_cpha),
    .start     (xfer_start),
    .load_data (tx_load),
    .lead_ev   (tmr_lead),
    .trail_ev  (tmr_trail),
    .last_ev   (xfer_last),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );
endmodule

// File: rtl/bspi_master_chk.sv
module bspi_master_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cpol,
  input logic busy,
  input logic tick,
  input logic last_ev,
  input logic sclk,
  input logic mosi,
  input logic txe,
  input logic done,
  input logic rxf,
  input logic ovr,
  input logic rx_rd,
  input logic irq,
  input logic irq_sel,
  input logic armed
);
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $stable(cpol)) |-> (sclk == cpol));

  assert_sclk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && busy && !tick) |=> $stable(sclk));

  assert_mosi_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$fell(en)) |-> !mosi);

  assert_txe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$fell(en)) |-> txe);

  assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> done);

  assert_rx_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> rxf);

  assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ev && rxf && !rx_rd) |=> ovr);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_sel && !armed) |-> !irq);
endmodule

bind bspi_master bspi_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (cfg_en),
  .cpol    (cfg_cpol),
  .busy    (tmr_busy),
  .tick    (tmr_tick),
  .last_ev (xfer_last),
  .sclk    (sclk),
  .mosi    (mosi),
  .txe     (stat_txe),
  .done    (stat_done),
  .rxf     (stat_rxf),
  .ovr     (stat_ovr),
  .rx_rd   (rx_rd_pulse),
  .irq     (irq),
  .irq_sel (irq_sel),
  .armed   (irq_armed)
);

// File: tb/bspi_master_test.sv
`timescale 1ns/1ps
module bspi_master_test;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_sel = 1'b1;
  logic       irq, sclk, mosi, miso;

  bspi_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_sel(irq_sel), .irq(irq),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  // behavioural slave
  logic       m_cpol = 0, m_cpha = 0, m_lsb = 0;
  logic [7:0] slv_byte = 8'h00;
  int         lead_cnt = 0, cap_n = 0, ntr = 0, last_tr = -1, gmin = 1000, gmax = 0;
  logic       sclk_prev = 0;
  logic       cap [0:63];

  function automatic int bidx(int k);
    return m_lsb ? (k % 8) : (7 - (k % 8));
  endfunction

  always_comb begin
    if (m_cpha) miso = (lead_cnt == 0) ? 1'b0 : slv_byte[bidx(lead_cnt - 1)];
    else        miso = slv_byte[bidx(lead_cnt)];
  end

  always @(negedge clk) begin
    if (sclk !== sclk_prev) begin
      logic lead;
      lead = (sclk != m_cpol);
      if (lead) lead_cnt++;
      if (lead == !m_cpha && cap_n < 64) begin
        cap[cap_n] = mosi;
        cap_n++;
      end
      if (last_tr >= 0) begin
        if (cyc - last_tr < gmin) gmin = cyc - last_tr;
        if (cyc - last_tr > gmax) gmax = cyc - last_tr;
      end
      last_tr = cyc;
      ntr++;
      sclk_prev = sclk;
    end
  end

  function automatic logic [7:0] cap_byte(int k);
    logic [7:0] v = 8'h00;
    for (int i = 0; i < 8; i++) v[bidx(i)] = cap[8*k + i];
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic slave_reset();
    @(posedge clk); #1;
    sclk_prev = sclk; lead_cnt = 0; cap_n = 0; ntr = 0; last_tr = -1; gmin = 1000; gmax = 0;
  endtask

  task automatic configure(input logic lsb, input logic cpha, input logic cpol);
    wr(2'd0, 8'h00);
    wr(2'd0, {lsb, 4'b0000, cpha, cpol, 1'b1});
    m_lsb = lsb; m_cpha = cpha; m_cpol = cpol;
    repeat (2) @(negedge clk);
    slave_reset();
  endtask

  task automatic wait_irq();
    int t = 0;
    while (!irq && t < 400) begin @(negedge clk); t++; end
    chk("R7 irq on done", irq, 1);
  endtask

  function automatic logic [7:0] exp_ctrl(logic lsb, logic ovr, logic done, logic txe,
                                          logic rxf, logic cpha, logic cpol, logic en);
    return {lsb, ovr, done, txe, rxf, cpha, cpol, en};
  endfunction

  initial begin
    #1_900_000;
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] a_byte, b_byte;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl reset", d, 8'h10);
    rd(2'd2, d); chk("R1 rx reset", d, 8'h00);
    rd(2'd1, d); chk("R1 addr1 reads 0", d, 8'h00);
    rd(2'd3, d); chk("R1 addr3 reads 0", d, 8'h00);
    chk("R1 sclk low", sclk, 0);
    chk("R1 mosi low", mosi, 0);
    chk("R1 irq low", irq, 0);

    // R6 write to TX while disabled is ignored
    slave_reset();
    wr(2'd1, 8'hA5);
    rd(2'd0, d); chk("R6 tx write ignored when off", d, 8'h10);
    irq_sel = 1'b0;
    wr(2'd0, 8'h01);
    repeat (40) @(negedge clk);
    chk("R6 no transfer from ignored write", ntr, 0);
    chk("R9 irq not armed at enable", irq, 0);
    rd(2'd0, d); chk("R6 txe after enable", d, 8'h11);

    // R2 configuration lock
    wr(2'd0, 8'h87);
    rd(2'd0, d); chk("R2 config locked while enabled", d, 8'h11);
    wr(2'd0, 8'h86);
    rd(2'd0, d); chk("R2 disable keeps config", d, 8'h10);
    wr(2'd0, 8'h87);
    rd(2'd0, d); chk("R2 config and enable together", d, 8'h97);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R2 disable write changes only bit0", d, 8'h96);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R2 config cleared while off", d, 8'h10);
    irq_sel = 1'b1;

    // sweep: modes x bit orders x byte pairs (R3 R4 R5 R7 R8)
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic lsb, cpha, cpol;
      lsb = cfg[2]; cpha = cfg[1]; cpol = cfg[0];
      configure(lsb, cpha, cpol);
      chk("R3 idle level", sclk, cpol);
      for (int b = 0; b < 256; b += 3) begin
        logic [7:0] tx, sv;
        tx = 8'(b);
        sv = 8'(b * 37 + 11);
        slv_byte = sv;
        slave_reset();
        wr(2'd1, tx);
        wait_irq();
        @(negedge clk);
        chk("R3 transitions per byte", ntr, 16);
        chk("R3 min spacing", gmin, HALF);
        chk("R3 max spacing", gmax, HALF);
        chk("R3 sclk back at idle", sclk, cpol);
        chk("R4 mosi byte", cap_byte(0), tx);
        rd(2'd2, d); chk("R5 received byte", d, sv);
        rd(2'd0, d); chk("R7 R8 ctrl after byte", d, exp_ctrl(lsb, 0, 1, 1, 0, cpha, cpol, 1));
        rd(2'd0, d); chk("R7 done cleared by read", d, exp_ctrl(lsb, 0, 0, 1, 0, cpha, cpol, 1));
      end
    end

    // R9 interrupt arming on TX empty
    wr(2'd0, 8'h00);
    irq_sel = 1'b0;
    wr(2'd0, 8'h01);
    m_lsb = 0; m_cpha = 0; m_cpol = 0;
    repeat (2) @(negedge clk);
    slave_reset();
    chk("R9 irq held off after enable", irq, 0);
    slv_byte = 8'h3C;
    wr(2'd1, 8'hC3);
    repeat (3) @(negedge clk);
    chk("R9 irq after first move", irq, 1);
    irq_sel = 1'b1; #1;
    chk("R9 sel done, not yet done", irq, 0);
    wait_irq();
    rd(2'd2, d); chk("R5 rx in irq test", d, 8'h3C);
    rd(2'd0, d); chk("R9 ctrl after done", d, 8'h31);

    // R6 back-to-back bytes, R8 overrun
    a_byte = 8'h96; b_byte = 8'h4E;
    slv_byte = 8'hE1;
    slave_reset();
    wr(2'd1, a_byte);
    wr(2'd1, b_byte);
    rd(2'd0, d); chk("R6 txe cleared while waiting", d, 8'h01);
    begin
      int t = 0;
      while (cap_n < 16 && t < 400) begin @(negedge clk); t++; end
    end
    repeat (3) @(negedge clk);
    chk("R6 transitions for two bytes", ntr, 32);
    chk("R6 no gap min", gmin, HALF);
    chk("R6 no gap max", gmax, HALF);
    chk("R6 first byte out", cap_byte(0), a_byte);
    chk("R6 second byte out", cap_byte(1), b_byte);
    rd(2'd0, d); chk("R8 overrun set", d, 8'h79);
    rd(2'd0, d); chk("R8 overrun cleared by ctrl read", d, 8'h19);
    rd(2'd2, d); chk("R8 rx byte", d, 8'hE1);
    rd(2'd0, d); chk("R8 rx full cleared by rx read", d, 8'h11);

    // R10 abort mid-byte
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h07);
    m_lsb = 0; m_cpha = 1; m_cpol = 1;
    repeat (2) @(negedge clk);
    slave_reset();
    slv_byte = 8'hFF;
    wr(2'd1, 8'hFF);
    repeat (9) @(negedge clk);
    chk("R10 transfer running", (ntr > 0) ? 1 : 0, 1);
    wr(2'd0, 8'h06);
    repeat (3) @(negedge clk);
    chk("R10 sclk idle after abort", sclk, 1);
    chk("R10 mosi low after abort", mosi, 0);
    slave_reset();
    repeat (40) @(negedge clk);
    chk("R10 no further edges", ntr, 0);
    rd(2'd0, d); chk("R10 ctrl after abort", d, 8'h16);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule